// File: doc/BRIEF.md
# CPU Cluster Performance-State Controller

This block sits between software and a clock/voltage sequencer for one CPU cluster. Software asks for a new performance state by writing a command word with a request bit set. The controller clamps the state to the highest state the cluster supports and records it as the target. It raises a busy flag and sends a one-cycle request to the sequencer. When the sequencer reports that the transition is done, the controller makes the target the current state, clears busy, and stores a timestamp sampled from a free-running counter.

At the same edge it loads the PLL multiplier and divider pair for the new state. That pair comes from a per-state table generated from parameters. The pair is readable as a register and is also driven on an output.

Software reaches every register through a 64-bit read/write port addressed by byte offset, and reads are combinational. A write that arrives while a transition is pending is dropped. Software is expected to poll busy and to write the same state into both state fields of the command word.

Top module: `pstate_ctl`

## Requirements
- R1: After reset, the command, status and change-time registers read 0. The PLL register and `pllRatio` hold the table entry for state 0, and `seqReq` is low.
- R2: A write to offset 0x20 with bit 25 set while idle is accepted. From the next cycle, bit 31 of offset 0x20 reads 1 and `seqReq` is high for exactly one cycle with `seqTarget` equal to the accepted (clamped) target.
- R3: Offset 0x20 reads busy in bit 31, the last accepted primary state in bits 4:0 and the last accepted secondary state in bits 16:12. Bit 25 always reads 0.
- R4: Offset 0x50 reads the target state in bits 4:0 and the current state in bits 9:5. The target takes the new value in the cycle after a request is accepted.
- R5: When `seqDone` is high while busy, the current state takes the target value and busy clears, both at that clock edge.
- R6: Offset 0x38 holds the value of `tsCount` sampled at the clock edge where a transition completes.
- R7: At completion, offset 0xC8 and `pllRatio` load the pair for the new state, with the multiplier in bits 31:16 and the divider minus one in bits 15:0. The multiplier is MULT_BASE + state*MULT_STEP (truncated to 16 bits). The divider-minus-one is 1 for states below DIV_SPLIT and 0 otherwise. The pair changes at no other time.
- R8: A command write while busy is ignored. It changes neither the target nor the command fields, and it raises no `seqReq`.
- R9: A requested state above MAX_STATE is clamped to MAX_STATE before it is latched. This applies to both state fields.
- R10: A write to offset 0x20 with bit 25 clear, or a write to any other offset, changes no register.
- R11: `seqDone` while idle is ignored. Busy, current state, timestamp and PLL pair are unchanged.
- R12: Reads from offsets other than 0x20, 0x38, 0x50 and 0xC8 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte offset for read and write |
| regWe | input | 1 | Write strobe |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data for `regAddr` (combinational) |
| tsCount | input | 64 | Free-running timestamp counter value |
| seqReq | output | 1 | One-cycle transition request to the sequencer |
| seqTarget | output | 5 | Target state presented to the sequencer |
| seqDone | input | 1 | Transition-complete pulse from the sequencer |
| pllRatio | output | 32 | Multiplier (31:16) and divider minus one (15:0) of the current state |

## Verification
The bench builds the block with MAX_STATE at 20, so 5-bit requests from 21 to 31 reach the clamp. MULT_STEP is 3 and DIV_SPLIT is 12, which makes both divider values and distinct multipliers visible across the states it requests. Its modelled sequencer answers each request five cycles later, which leaves time to write during busy and to observe the held target. A manual done pulse while idle exercises the case where `seqDone` must be ignored.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  localparam int STATE_W = 5;
  localparam int REG_W   = 64;
  localparam int ADDR_W  = 8;
  localparam int HALF_W  = 16;
  localparam int TBL_N   = 1 << STATE_W;

  // Offsets decoded by software; kept fixed.
  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_TIME = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_PLL  = 8'hC8;

  localparam int BUSY_BIT = 31;
  localparam int REQ_BIT  = 25;
  localparam int SEC_LSB  = 12;
  localparam int CUR_LSB  = 5;

  typedef struct packed {
    logic accept;
    logic complete;
  } seqStrobe_t;

  typedef struct packed {
    logic [HALF_W-1:0] mult;
    logic [HALF_W-1:0] divM1;
  } pllPair_t;
endpackage

// File: rtl/pstate_seq.sv
module pstate_seq
  import pstate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic       setReq,
  input  logic       seqDone,
  output logic       busy,
  output logic       seqReq,
  output seqStrobe_t strobe
);
  // accept needs idle, complete needs busy: the two never coincide.
  always_comb begin
    strobe.accept   = cmdWrite && setReq && !busy;
    strobe.complete = busy && seqDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      seqReq <= 1'b0;
    end else begin
      seqReq <= strobe.accept;
      if (strobe.accept)
        busy <= 1'b1;
      else if (strobe.complete)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/pstate_regs.sv
module pstate_regs
  import pstate_pkg::*;
#(
  parameter int MAX_STATE = 31,
  parameter int MULT_BASE = 20,
  parameter int MULT_STEP = 4,
  parameter int DIV_SPLIT = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               busy,
  input  logic [STATE_W-1:0] wrPri,
  input  logic [STATE_W-1:0] wrSec,
  input  logic [REG_W-1:0]   tsCount,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  output logic [STATE_W-1:0] target,
  output pllPair_t           pllNow
);
  localparam logic [STATE_W-1:0] MAX_S = STATE_W'(MAX_STATE);

  pllPair_t pllTable [TBL_N];

  generate
    for (genvar s = 0; s < TBL_N; s++) begin : g_tbl
      localparam int MULT_V = MULT_BASE + s * MULT_STEP;
      assign pllTable[s].mult  = HALF_W'(MULT_V);
      assign pllTable[s].divM1 = (s < DIV_SPLIT) ? HALF_W'(1) : HALF_W'(0);
    end
  endgenerate

  function automatic logic [STATE_W-1:0] clampState(input logic [STATE_W-1:0] v);
    return (v > MAX_S) ? MAX_S : v;
  endfunction

  logic [STATE_W-1:0] priQ, secQ, tgtQ, curQ;
  logic [REG_W-1:0]   tsQ;
  pllPair_t           pllQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priQ <= '0;
      secQ <= '0;
      tgtQ <= '0;
      curQ <= '0;
      tsQ  <= '0;
      pllQ <= pllTable[0];
    end else begin
      if (strobe.accept) begin
        priQ <= clampState(wrPri);
        secQ <= clampState(wrSec);
        tgtQ <= clampState(wrPri);
      end
      if (strobe.complete) begin
        curQ <= tgtQ;
        tsQ  <= tsCount;
        pllQ <= pllTable[tgtQ];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFF_CMD: begin
        rdData[BUSY_BIT]                 = busy;
        rdData[SEC_LSB +: STATE_W]       = secQ;
        rdData[STATE_W-1:0]              = priQ;
      end
      OFF_STAT: begin
        rdData[CUR_LSB +: STATE_W]       = curQ;
        rdData[STATE_W-1:0]              = tgtQ;
      end
      OFF_TIME: rdData = tsQ;
      OFF_PLL:  rdData[2*HALF_W-1:0]     = pllQ;
      default:  rdData = '0;
    endcase
  end

  assign target = tgtQ;
  assign pllNow = pllQ;
endmodule

// File: rtl/pstate_ctl.sv
module pstate_ctl
  import pstate_pkg::*;
#(
  parameter int MAX_STATE = 31,
  parameter int MULT_BASE = 20,
  parameter int MULT_STEP = 4,
  parameter int DIV_SPLIT = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWe,
  input  logic [63:0] regWdata,
  output logic [63:0] regRdata,
  input  logic [63:0] tsCount,
  output logic        seqReq,
  output logic [4:0]  seqTarget,
  input  logic        seqDone,
  output logic [31:0] pllRatio
);
  logic       busy;
  logic       cmdWrite;
  seqStrobe_t strobe;
  pllPair_t   pllNow;
  logic       unusedWdata;

  assign cmdWrite    = regWe && (regAddr == OFF_CMD);
  assign unusedWdata = ^{regWdata[63:26], regWdata[24:17], regWdata[11:5]};

  pstate_seq u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .setReq   (regWdata[REQ_BIT]),
    .seqDone  (seqDone),
    .busy     (busy),
    .seqReq   (seqReq),
    .strobe   (strobe)
  );

  pstate_regs #(
    .MAX_STATE (MAX_STATE),
    .MULT_BASE (MULT_BASE),
    .MULT_STEP (MULT_STEP),
    .DIV_SPLIT (DIV_SPLIT)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busy    (busy),
    .wrPri   (regWdata[STATE_W-1:0]),
    .wrSec   (regWdata[SEC_LSB +: STATE_W]),
    .tsCount (tsCount),
    .rdAddr  (regAddr),
    .rdData  (regRdata),
    .target  (seqTarget),
    .pllNow  (pllNow)
  );

  assign pllRatio = pllNow;
endmodule

// File: rtl/pstate_ctl_chk.sv
module pstate_ctl_chk #(
  parameter int MAX_STATE = 31
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [7:0]  regAddr,
  input logic        setBit,
  input logic        seqDone,
  input logic        seqReq,
  input logic        busy,
  input logic [4:0]  seqTarget,
  input logic [31:0] pllRatio
);
  logic acceptW;
  assign acceptW = regWe && (regAddr == pstate_pkg::OFF_CMD) && setBit && !busy;

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    acceptW |=> (busy && seqReq));

  a_r2_req_single: assert property (@(posedge clk) disable iff (!rstN)
    seqReq |=> !seqReq);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busy && seqDone) |=> !busy);

  a_r8_target_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(seqTarget));

  a_r9_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (32'(seqTarget) <= MAX_STATE));

  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !acceptW) |=> (!busy && $stable(pllRatio)));

  a_r7_pll_only_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && seqDone) |=> $stable(pllRatio));
endmodule

bind pstate_ctl pstate_ctl_chk #(.MAX_STATE(MAX_STATE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .setBit    (regWdata[25]),
  .seqDone   (seqDone),
  .seqReq    (seqReq),
  .busy      (busy),
  .seqTarget (seqTarget),
  .pllRatio  (pllRatio)
);

// File: tb/pstate_ctl_tb.sv
`timescale 1ns/100ps
module pstate_ctl_tb;
  localparam int MAX_S  = 20;
  localparam int M_BASE = 20;
  localparam int M_STEP = 3;
  localparam int D_SPLIT = 12;
  localparam int LAT    = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic [63:0] tsCount = 64'h0000_1000_0000_0000;
  logic        seqReq;
  logic [4:0]  seqTarget;
  logic        seqDone;
  logic        autoDone = 1'b0;
  logic        manDone = 1'b0;
  logic [31:0] pllRatio;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  int latCnt = 0;
  logic [63:0] lastDoneTs = '0;
  bit finished = 0;

  assign seqDone = autoDone | manDone;
  always #2.5 clk = ~clk;

  pstate_ctl #(
    .MAX_STATE (MAX_S),
    .MULT_BASE (M_BASE),
    .MULT_STEP (M_STEP),
    .DIV_SPLIT (D_SPLIT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .tsCount(tsCount),
    .seqReq(seqReq), .seqTarget(seqTarget), .seqDone(seqDone),
    .pllRatio(pllRatio)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expPll(input int s);
    logic [15:0] m;
    m = 16'(M_BASE + s * M_STEP);
    return {32'b0, m, (s < D_SPLIT) ? 16'd1 : 16'd0};
  endfunction

  function automatic logic [63:0] cmdVal(input bit b, input int p, input int s);
    return (64'(b) << 31) | (64'(s) << 12) | 64'(p);
  endfunction

  function automatic logic [63:0] statVal(input int cur, input int tgt);
    return (64'(cur) << 5) | 64'(tgt);
  endfunction

  function automatic int clampM(input int v);
    return (v > MAX_S) ? MAX_S : v;
  endfunction

  // Modelled sequencer and scoreboard monitor
  always @(negedge clk) begin
    tsCount = tsCount + 64'd7;
    autoDone = 1'b0;
    if (latCnt > 0) begin
      latCnt--;
      if (latCnt == 0) begin
        autoDone = 1'b1;
        lastDoneTs = tsCount;
      end
    end
    if (rstN && seqReq) begin
      latCnt = LAT;
      if (expQ.size() == 0) begin
        chk("R8 unexpected seqReq", 64'd1, 64'd0);
      end else begin
        int e;
        e = expQ.pop_front();
        chk("R2 seqTarget", 64'(seqTarget), 64'(e));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic request(input int p, input int s, input bit acc);
    if (acc) expQ.push_back(clampM(p));
    wr(8'h20, (64'd1 << 25) | (64'(s) << 12) | 64'(p));
  endtask

  task automatic waitIdle();
    logic [63:0] v;
    for (int i = 0; i < 40; i++) begin
      rd(8'h20, v);
      if (!v[31]) break;
    end
    chk("R5 busy cleared", 64'(v[31]), 64'd0);
  endtask

  initial begin
    logic [63:0] v, s0, t0, p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h20, v); chk("R1 cmd reset", v, 64'd0);
    rd(8'h50, v); chk("R1 status reset", v, 64'd0);
    rd(8'h38, v); chk("R1 time reset", v, 64'd0);
    rd(8'hC8, v); chk("R1 pll reset", v, expPll(0));
    chk("R1 pllRatio reset", 64'(pllRatio), expPll(0));
    chk("R1 seqReq reset", 64'(seqReq), 64'd0);

    // R2 R3 R4 basic transition
    request(7, 7, 1);
    rd(8'h20, v); chk("R2 R3 cmd busy", v, cmdVal(1, 7, 7));
    rd(8'h50, v); chk("R4 status pending", v, statVal(0, 7));
    waitIdle();
    rd(8'h50, v); chk("R5 status done", v, statVal(7, 7));
    rd(8'h38, v); chk("R6 timestamp", v, lastDoneTs);
    rd(8'hC8, v); chk("R7 pll reg", v, expPll(7));
    chk("R7 pllRatio", 64'(pllRatio), expPll(7));

    // R8 write while busy ignored
    request(3, 3, 1);
    request(9, 9, 0);
    rd(8'h50, v); chk("R8 target kept", v, statVal(7, 3));
    rd(8'h20, v); chk("R8 cmd fields kept", v, cmdVal(1, 3, 3));
    waitIdle();
    rd(8'h50, v); chk("R8 status after", v, statVal(3, 3));
    rd(8'hC8, v); chk("R7 pll state 3", v, expPll(3));
    rd(8'h38, v); chk("R6 timestamp 2", v, lastDoneTs);

    // R9 clamp, both fields
    request(28, 2, 1);
    rd(8'h20, v); chk("R9 clamp primary", v, cmdVal(1, 20, 2));
    waitIdle();
    rd(8'h50, v); chk("R9 clamped status", v, statVal(20, 20));
    chk("R7 pllRatio state 20", 64'(pllRatio), expPll(20));
    request(31, 31, 1);
    rd(8'h20, v); chk("R9 clamp both", v, cmdVal(1, 20, 20));
    waitIdle();

    // R10 writes with no effect
    wr(8'h20, 64'h0000_0000_0000_5005);
    rd(8'h20, v); chk("R10 no set bit", v, cmdVal(0, 20, 20));
    rd(8'h38, t0);
    wr(8'h50, 64'h0000_0000_0000_0021);
    wr(8'h38, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'hC8, 64'h0000_0000_1234_5678);
    rd(8'h50, v); chk("R10 status write", v, statVal(20, 20));
    rd(8'h38, v); chk("R10 time write", v, t0);
    rd(8'hC8, v); chk("R10 pll write", v, expPll(20));

    // R11 done while idle
    rd(8'h50, s0); rd(8'h38, t0); rd(8'hC8, p0);
    @(negedge clk); #1; manDone = 1'b1;
    @(negedge clk); #1; manDone = 1'b0;
    rd(8'h20, v); chk("R11 busy idle", 64'(v[31]), 64'd0);
    rd(8'h50, v); chk("R11 status", v, s0);
    rd(8'h38, v); chk("R11 time", v, t0);
    rd(8'hC8, v); chk("R11 pll", v, p0);

    // Low state, divider switch back, then R12
    request(0, 0, 1);
    waitIdle();
    rd(8'hC8, v); chk("R7 pll state 0", v, expPll(0));
    rd(8'h00, v); chk("R12 unmapped 0x00", v, 64'd0);
    rd(8'h28, v); chk("R12 unmapped 0x28", v, 64'd0);
    rd(8'hFF, v); chk("R12 unmapped 0xFF", v, 64'd0);

    repeat (LAT + 3) @(negedge clk);
    chk("R8 scoreboard empty", 64'(expQ.size()), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule